// File: doc/BRIEF.md
# Glitchless Two-Source Clock Selector

This block takes two free-running clocks that share no phase or frequency relation and passes exactly one of them to a single clock output for downstream fanout. A level select input names the wanted source: low picks source A and high picks source B. When the select changes, the old source is cut off and the new one is admitted. The output never shows a pulse or gap shorter than a normal phase of either input.

Each source has its own gate. The gate is opened and closed only by flops on that source's falling edge, so it changes only while its clock is low. A gate may open only after the other gate has been seen closed through a synchroniser in the opening source's own domain. Between the moment the old gate closes and the moment the new one opens, the output rests low. After reset both gates are closed, and source A, the power-on choice, is admitted once its own falling edges have carried the request through the synchroniser. A source that is absent rests low, so selecting it yields a quiet, low output.

The select must stay stable for longer than one full handoff before it changes again. The synchroniser depth is the parameter `SYNC_STAGES`, with 2 as the minimum and the default.

Top module: `glitchless_clk_sel`

## Requirements
- R1: After a handoff completes, every rising edge of `clk_o` coincides with a rising edge of the selected source, and every rising edge of that source shows up on `clk_o`. A select of 0 chooses `clk_a_i`; a select of 1 chooses `clk_b_i`.
- R2: Outside reset, no high or low phase on `clk_o` is shorter than the smaller half-period of the two inputs. This holds across every select change.
- R3: The two source gates are never open together. After a select change, the old source contributes at most `SYNC_STAGES` further pulses to `clk_o`.
- R4: While `rst_n_i` is low, `clk_o` stays low and both gates are closed. After release with select 0, `clk_o` stays quiet until the `SYNC_STAGES`-th falling edge of `clk_a_i`. It carries `clk_a_i` from the next rising edge onward.
- R5: Once (`SYNC_STAGES`+1) periods of the old source plus (`SYNC_STAGES`+2) periods of the new source have passed after a select change, `clk_o` carries no more pulses from the deselected source.
- R6: If the newly selected source is held low (absent), `clk_o` stays low after the old source is cut off. When the new source starts running, the handoff completes.
- R7: If the source that owns the output stops in its low state and the select then moves away, `clk_o` stays low with no pulses from the other source. When the stopped source runs again, the handoff completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | Source A clock, chosen when the select is 0 |
| clk_b_i | input | 1 | Source B clock, chosen when the select is 1 |
| rst_n_i | input | 1 | Asynchronous active-low reset; closes both gates |
| sel_i | input | 1 | Level select: 0 for source A, 1 for source B |
| clk_o | output | 1 | Selected clock, held low while no gate is open |

## Verification
The clock pairs have random half-periods drawn from a fixed seed, plus directed pairs that are nearly equal or very far apart in frequency. These separate a handoff that only works when one domain is much faster from one that works for any pair. Switches happen at random phase offsets, and a select rewrite to the same value is included, to tell a real handoff from a disturbance of a path that is already settled. Every output phase is measured and every output pulse is attributed to a source: clipped phases show up as R2 failures, and overlapping or late cut-offs show up as R3 or R5 failures. Directed runs stop one source in its low state, either the source being chosen or the source that owns the output. These separate a design that waits for the other domain from one that opens its gate without that acknowledgement.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

  // Source identifiers. The value is the select level that picks the source.
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } gcs_src_e;

  localparam int unsigned GCS_NUM_SRC    = 2;
  // Shortest synchroniser that still resolves metastability between domains.
  localparam int unsigned GCS_MIN_STAGES = 2;

endpackage

// File: rtl/gcs_sync.sv
// Falling-edge synchroniser chain with asynchronous clear.
module gcs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  // Capture on the falling edge so the output only moves while clk_i is low.
  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gcs_leg.sv
// One source path: request logic, a synchroniser in this source's domain,
// and the AND gate that passes the clock.
module gcs_leg
  import gcs_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter gcs_src_e    SRC_ID = SRC_A
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sel_i,
  input  logic peer_en_i,
  output logic en_o,
  output logic gated_o
);

  localparam int unsigned CW = $clog2(STAGES + 1);

  logic want;
  logic req;

  assign want = (sel_i == logic'(SRC_ID));
  // Ask for the output only while the peer gate is seen closed.
  assign req  = want & ~peer_en_i;

  gcs_sync #(
    .STAGES(STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .d_i    (req),
    .q_o    (en_o)
  );

  // en_o only changes on a falling edge, so the AND cannot clip a high phase.
  assign gated_o = clk_i & en_o;

  // Checker state: edges seen since reset, and edges since this source
  // was last wanted. Both saturate at STAGES.
  logic [CW-1:0] wake_cnt_q;
  logic [CW-1:0] idle_cnt_q;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wake_cnt_q <= '0;
      idle_cnt_q <= '0;
    end else begin
      if (wake_cnt_q != CW'(STAGES)) begin
        wake_cnt_q <= wake_cnt_q + CW'(1);
      end
      if (want) begin
        idle_cnt_q <= '0;
      end else if (idle_cnt_q != CW'(STAGES)) begin
        idle_cnt_q <= idle_cnt_q + CW'(1);
      end
    end
  end

  AST_WAKE_AFTER_RESET: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (wake_cnt_q < CW'(STAGES)) |-> !en_o); // R4

  AST_RELEASE_BOUND: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (idle_cnt_q == CW'(STAGES)) |-> !en_o); // R5

  AST_GRANT_PEER_IDLE: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    $rose(en_o) |-> !peer_en_i); // R3

endmodule

// File: rtl/glitchless_clk_sel.sv
// Glitch-free selector between two unrelated clocks.
module glitchless_clk_sel
  import gcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_n_i,
  input  logic sel_i,
  output logic clk_o
);

  localparam int unsigned STAGES =
    (SYNC_STAGES < GCS_MIN_STAGES) ? GCS_MIN_STAGES : SYNC_STAGES;

  logic [GCS_NUM_SRC-1:0] clk_vec;
  logic [GCS_NUM_SRC-1:0] en_vec;
  logic [GCS_NUM_SRC-1:0] gated_vec;

  assign clk_vec = {clk_b_i, clk_a_i};

  for (genvar g = 0; g < GCS_NUM_SRC; g++) begin : g_leg
    gcs_leg #(
      .STAGES(STAGES),
      .SRC_ID(gcs_src_e'(g))
    ) u_leg (
      .clk_i    (clk_vec[g]),
      .rst_n_i  (rst_n_i),
      .sel_i    (sel_i),
      .peer_en_i(en_vec[GCS_NUM_SRC-1-g]),
      .en_o     (en_vec[g]),
      .gated_o  (gated_vec[g])
    );
  end

  // At most one gate is open, so the OR passes a single source, or a steady low.
  assign clk_o = |gated_vec;

  AST_PATHS_EXCLUSIVE_A: assert property (@(negedge clk_a_i) disable iff (!rst_n_i)
    $onehot0(en_vec)); // R3

  AST_PATHS_EXCLUSIVE_B: assert property (@(negedge clk_b_i) disable iff (!rst_n_i)
    $onehot0(en_vec)); // R3

endmodule

// File: tb/glitchless_clk_sel_tb.sv
`timescale 1ns/1ps
module glitchless_clk_sel_tb;

  localparam int STAGES = 2;

  logic clk_ref = 1'b0;
  logic clk_a   = 1'b0;
  logic clk_b   = 1'b0;
  logic rst_n   = 1'b1;
  logic sel     = 1'b0;
  logic clk_o;

  realtime half_a = 5.0;
  realtime half_b = 3.3;
  bit      run_a  = 1'b1;
  bit      run_b  = 1'b1;

  int vectors     = 0;
  int miscompares = 0;
  bit done        = 1'b0;

  glitchless_clk_sel #(.SYNC_STAGES(STAGES)) u_dut (
    .clk_a_i(clk_a),
    .clk_b_i(clk_b),
    .rst_n_i(rst_n),
    .sel_i  (sel),
    .clk_o  (clk_o)
  );

  always #2 clk_ref = ~clk_ref;  // 250 MHz reference for the watchdog

  // Source generators. A stopped source finishes its high phase, then rests low.
  initial begin
    #1.37;
    forever begin
      #(half_a);
      if (run_a || clk_a) clk_a = ~clk_a;
    end
  end
  initial begin
    #2.71;
    forever begin
      #(half_b);
      if (run_b || clk_b) clk_b = ~clk_b;
    end
  end

  // Edge bookkeeping and attribution of output pulses to a source.
  int      rises [2];
  int      pulses[2];
  int      pulses_x;
  realtime t_rise[2];
  realtime t_out;

  always @(posedge clk_a) begin rises[0]++; t_rise[0] = $realtime; end
  always @(posedge clk_b) begin rises[1]++; t_rise[1] = $realtime; end
  always @(posedge clk_o) begin
    t_out = $realtime;
    #0.001;
    if (t_rise[0] == t_out) pulses[0]++;
    else if (t_rise[1] == t_out) pulses[1]++;
    else pulses_x++;
  end

  // Phase-width monitor (R2).
  bit      mon_en    = 1'b0;
  bit      have_last = 1'b0;
  realtime last_t;
  realtime now_t;
  realtime lim_t;

  always @(clk_o) begin
    now_t = $realtime;
    if (mon_en && have_last) begin
      lim_t = ((half_a < half_b) ? half_a : half_b) - 0.002;
      vectors++;
      if ((now_t - last_t) < lim_t) begin
        miscompares++;
        $display("FAIL R2 phase width: actual %0.3f ns expected >= %0.3f ns",
                 now_t - last_t, lim_t);
      end
    end
    last_t    = now_t;
    have_last = mon_en;
  end

  function automatic realtime handoff_bound(input realtime h_old, input realtime h_new);
    return 2.0 * h_old * (STAGES + 1) + 2.0 * h_new * (STAGES + 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    rises[0] = 0; rises[1] = 0;
    pulses[0] = 0; pulses[1] = 0;
    pulses_x = 0;
  endtask

  task automatic do_reset(input realtime ha, input realtime hb);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    run_a  = 1'b1;
    run_b  = 1'b1;
    sel    = 1'b0;
    half_a = ha;
    half_b = hb;
    #(20.0 * (ha + hb));
    clear_counts();
    #(20.0 * (ha + hb));
    chk(pulses[0] + pulses[1] + pulses_x == 0, "R4 no output pulses in reset",
        pulses[0] + pulses[1] + pulses_x, 0);
    chk(clk_o == 1'b0, "R4 output low in reset", int'(clk_o), 0);
    #0.37;
    rst_n = 1'b1;
    clear_counts();
    mon_en = 1'b1;
    repeat (STAGES) @(negedge clk_a);
    #0.01;
    chk(pulses[0] + pulses[1] + pulses_x == 0, "R4 quiet until wake edge",
        pulses[0] + pulses[1] + pulses_x, 0);
    @(posedge clk_a);
    #(ha / 2.0);
    chk(clk_o == 1'b1, "R4 source A reaches output after wake", int'(clk_o), 1);
  endtask

  task automatic window_check(input int s, input int n);
    if (s == 0) @(negedge clk_a); else @(negedge clk_b);
    clear_counts();
    for (int i = 0; i < n; i++) begin
      if (s == 0) @(negedge clk_a); else @(negedge clk_b);
    end
    #0.01;
    chk(pulses[s] == rises[s], "R1 output follows selected source", pulses[s], rises[s]);
    chk(pulses[1-s] == 0, "R5 no pulses from deselected source", pulses[1-s], 0);
    chk(pulses_x == 0, "R1 no unattributed output pulses", pulses_x, 0);
  endtask

  task automatic switch_to(input int s);
    realtime h_old;
    realtime h_new;
    h_old = (s == 0) ? half_b : half_a;
    h_new = (s == 0) ? half_a : half_b;
    clear_counts();
    sel = s[0];
    #(handoff_bound(h_old, h_new));
    chk(pulses[1-s] <= STAGES, "R3 old source pulses after change (expected <=)",
        pulses[1-s], STAGES);
    window_check(s, 12);
  endtask

  initial begin
    void'($urandom(32'h5EED_C10C));
    #0.1;
    rst_n = 1'b0;

    for (int run = 0; run < 5; run++) begin
      realtime ha;
      realtime hb;
      if (run == 0) begin ha = 4.0; hb = 4.0013; end        // nearly equal
      else if (run == 1) begin ha = 1.7; hb = 9.1; end      // wide ratio
      else begin
        ha = 1.6 + $urandom_range(0, 7400) / 1000.0;
        hb = 1.6 + $urandom_range(0, 7400) / 1000.0;
      end
      do_reset(ha, hb);
      window_check(0, 10);
      for (int k = 0; k < 6; k++) begin
        int ns;
        #($urandom_range(0, 2000) / 100.0);
        ns = int'($urandom_range(0, 1));
        if (ns != int'(sel)) switch_to(ns);
        else begin
          sel = ns[0];  // rewrite with same value: path must stay settled
          window_check(ns, 8);
        end
      end
    end

    // R6: select a source that is absent (held low).
    if (sel != 1'b0) switch_to(0);
    run_b = 1'b0;
    #(4.0 * half_b + 1.0);
    clear_counts();
    sel = 1'b1;
    #(2.0 * half_a * (STAGES + 1) + 1.0);
    chk(pulses[0] <= STAGES, "R3 old source cut off toward absent source", pulses[0], STAGES);
    clear_counts();
    #(60.0 * half_a);
    chk(pulses[0] + pulses[1] + pulses_x == 0, "R6 output quiet with absent source",
        pulses[0] + pulses[1] + pulses_x, 0);
    chk(clk_o == 1'b0, "R6 output low with absent source", int'(clk_o), 0);
    run_b = 1'b1;
    #(handoff_bound(half_a, half_b));
    window_check(1, 12);

    // R7: the owning source stops low, then the select moves away.
    run_b = 1'b0;
    #(4.0 * half_b + 1.0);
    clear_counts();
    sel = 1'b0;
    #(60.0 * half_a);
    chk(pulses[0] + pulses[1] + pulses_x == 0, "R7 no pulses while owner is stopped",
        pulses[0] + pulses[1] + pulses_x, 0);
    chk(clk_o == 1'b0, "R7 output low while owner is stopped", int'(clk_o), 0);
    run_b = 1'b1;
    #(handoff_bound(half_b, half_a));
    window_check(0, 12);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule